// File: doc/BRIEF.md
# Dual-Mode UART Oversampling Tick Generator

This block makes the 16x oversampling tick that a UART transmitter and receiver share, plus a strobe that marks every sixteenth tick, one per bit period. It runs from a fixed peripheral clock. A 16-bit reload value and a mode pin select one of two schemes. The integer scheme is a reloading down-counter that fires once every `reload` clocks. The fractional scheme is a 16-bit phase accumulator: `reload` is added every clock and each carry out of the top bit is a tick. The accumulator mode suits high baud rates, where an integer divider would have a large rate error. As an example, a 200 MHz clock and 115200 baud need an increment of 604.

Software clears `run_en`, changes `reload` and `nco_mode`, and then sets `run_en` again. On the first clock with `run_en` high, the generator captures both values and starts from a known phase. Changes made while it runs are ignored. No data stream passes through the block, so all pins are plain level controls and single-cycle pulses, and there is no valid/ready handshake or back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `tick16` and `bit_strobe` are low.
- R2: With `nco_mode`=0 and a captured reload N≥2, `tick16` is first high in the cycle after the Nth rising edge that follows the start edge. After that it is high once every N cycles, for exactly one cycle.
- R3: With `nco_mode`=0 and a captured reload of 0 or 1, `tick16` is high after every rising edge that follows the start edge.
- R4: With `nco_mode`=1 and a captured increment R, the accumulator starts at 0. Over the first k edges after the start edge, exactly floor(k·R/65536) ticks occur.
- R5: After an edge at which `run_en` is sampled low, `tick16` and `bit_strobe` are low, and they stay low while `run_en` stays low.
- R6: The start edge is the first edge at which `run_en` is sampled high after it was low or after reset. `tick16` is low in the cycle that follows the start edge.
- R7: The block captures `reload` and `nco_mode` only at the start edge. Changes to either input while running have no effect on the tick pattern until the next start.
- R8: `bit_strobe` is high in the same cycle as every 16th `tick16` pulse counted from the start edge. It is never high without `tick16`. Its count restarts from zero at every start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable. Low holds the block idle |
| nco_mode | input | 1 | 0 selects the integer divider, 1 selects the phase accumulator |
| reload | input | 16 | Divider reload value or accumulator increment |
| tick16 | output | 1 | One-cycle 16x oversampling tick |
| bit_strobe | output | 1 | One-cycle pulse on every 16th tick |

## Verification
The bench counts ticks and strobes over windows whose expected totals are exact floor expressions. It uses fixed windows and randomly chosen ones, with random reload values in both modes.

Reload values of 0 and 1 are tested directly. A divider that let its counter wrap on these values would produce roughly 65536-cycle gaps instead of a tick every cycle. The first-tick position after a start is checked cycle by cycle, so a divider that is off by one in its load or expiry shows up at once.

Reload and mode are changed in mid-run. A design that sampled these inputs live, instead of capturing them at the start, would change rate, and the window total would differ. Idle and strobe phase are checked after each stop and restart. A strobe counter that did not clear would fire early on the next run.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic {
    GEN_DIV = 1'b0,
    GEN_NCO = 1'b1
  } gen_mode_e;

  localparam int unsigned DEF_RELOAD_W = 16;
  localparam int unsigned DEF_OVS      = 16;
endpackage

// File: rtl/baudgen_div_core.sv
module baudgen_div_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         go,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         expire;

  // values 0 and 1 both expire at once: one tick per clock, no wrap
  assign expire = (cnt_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (start) begin
      cnt_q  <= reload_i;
      tick_o <= 1'b0;
    end else if (go) begin
      if (expire) begin
        cnt_q  <= reload_i;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - W'(1);
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baudgen_nco_core.sv
module baudgen_nco_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         go,
  input  logic [W-1:0] inc_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (start) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (go) begin
      acc_q  <= sum[W-1:0];
      tick_o <= sum[W];
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baudgen_strobe_div.sv
module baudgen_strobe_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick_i,
  output logic strobe_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (!active) begin
      sub_q <= '0;
    end else if (tick_i) begin
      sub_q <= (sub_q == LAST) ? '0 : sub_q + CW'(1);
    end
  end

  assign strobe_o = tick_i && (sub_q == LAST);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter int unsigned RELOAD_W = DEF_RELOAD_W,
  parameter int unsigned OVS      = DEF_OVS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                nco_mode,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick16,
  output logic                bit_strobe
);
  logic                active_q;
  logic [RELOAD_W-1:0] reload_sh_q;
  gen_mode_e           mode_sh_q;
  logic                start;
  logic                go;
  logic [RELOAD_W-1:0] eff_reload;
  logic                div_tick;
  logic                nco_tick;

  assign start      = run_en && !active_q;
  assign go         = run_en && active_q;
  assign eff_reload = start ? reload : reload_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      reload_sh_q <= '0;
      mode_sh_q   <= GEN_DIV;
    end else begin
      active_q <= run_en;
      if (start) begin
        reload_sh_q <= reload;
        mode_sh_q   <= gen_mode_e'(nco_mode);
      end
    end
  end

  baudgen_div_core #(.W(RELOAD_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start && (nco_mode == GEN_DIV)),
    .go       (go && (mode_sh_q == GEN_DIV)),
    .reload_i (eff_reload),
    .tick_o   (div_tick)
  );

  baudgen_nco_core #(.W(RELOAD_W)) i_nco (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start && (nco_mode == GEN_NCO)),
    .go     (go && (mode_sh_q == GEN_NCO)),
    .inc_i  (eff_reload),
    .tick_o (nco_tick)
  );

  assign tick16 = div_tick || nco_tick;

  baudgen_strobe_div #(.OVS(OVS)) i_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active_q),
    .tick_i   (tick16),
    .strobe_o (bit_strobe)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic tick16,
  input logic bit_strobe
);
  // R5
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!tick16 && !bit_strobe));

  // R6
  quiet_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> !tick16);

  // R8
  strobe_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick16);

  // R8
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
endmodule

bind baud_tick_gen baud_tick_gen_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .tick16     (tick16),
  .bit_strobe (bit_strobe)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        nco_mode = 1'b0;
  logic [15:0] reload = '0;
  logic        tick16;
  logic        bit_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .nco_mode(nco_mode),
    .reload(reload), .tick16(tick16), .bit_strobe(bit_strobe)
  );

  function automatic longint exp_ticks(input bit m, input int n, input int w);
    if (m) return (longint'(w) * n) / 65536;
    return w / ((n < 1) ? 1 : n);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start at negedge, count W samples after the edges following the start edge
  task automatic run_window(input bit m, input int n, input int w, input bit swap,
                            output int tk, output int sb);
    tk = 0; sb = 0;
    nco_mode = m; reload = 16'(n); run_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (tick16) tk++;
      if (bit_strobe) sb++;
      if (swap && i == 10) begin
        nco_mode = ~m;
        reload = 16'(n + 3);
      end
    end
  endtask

  task automatic stop_and_check(input string req);
    int busy;
    busy = 0;
    run_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick16 || bit_strobe) busy++;
    end
    check(req, busy, 0);
  endtask

  initial begin
    int tk, sb, first;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 tick in reset", tick16, 0);
    check("R1 strobe in reset", bit_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick after reset", tick16, 0);

    // R2 / R6 first tick position, N=7
    nco_mode = 1'b0; reload = 16'd7; run_en = 1'b1;
    @(negedge clk);
    check("R6 no tick after start edge", tick16, 0);
    first = 0;
    for (int i = 1; i <= 20 && first == 0; i++) begin
      @(negedge clk);
      if (tick16) first = i;
    end
    check("R2 first tick edge", first, 7);
    stop_and_check("R5 idle after stop");

    // R3 reload 0 and 1
    run_window(1'b0, 0, 100, 1'b0, tk, sb);
    check("R3 reload 0 ticks", tk, 100);
    check("R8 reload 0 strobes", sb, 6);
    stop_and_check("R5 idle");
    run_window(1'b0, 1, 64, 1'b0, tk, sb);
    check("R3 reload 1 ticks", tk, 64);
    check("R8 reload 1 strobes", sb, 4);
    stop_and_check("R5 idle");

    // R4 full accumulator period at increment 604
    run_window(1'b1, 604, 65536, 1'b0, tk, sb);
    check("R4 nco 604 ticks", tk, 604);
    check("R8 nco 604 strobes", sb, 37);
    stop_and_check("R5 idle");

    // R7 changes while running are ignored
    run_window(1'b0, 5, 500, 1'b1, tk, sb);
    check("R7 div swap ignored", tk, 100);
    stop_and_check("R5 idle");
    run_window(1'b1, 9000, 2000, 1'b1, tk, sb);
    check("R7 nco swap ignored", tk, exp_ticks(1'b1, 9000, 2000));
    stop_and_check("R5 idle");

    // R2 / R4 / R8 random windows
    for (int t = 0; t < 12; t++) begin
      bit m;
      int n, w;
      longint e;
      m = 1'($urandom_range(1, 0));
      n = m ? int'($urandom_range(60000, 1)) : int'($urandom_range(40, 2));
      w = int'($urandom_range(3000, 500));
      e = exp_ticks(m, n, w);
      run_window(m, n, w, 1'b0, tk, sb);
      check(m ? "R4 random nco ticks" : "R2 random div ticks", tk, e);
      check("R8 random strobes", sb, e / 16);
      stop_and_check("R5 idle random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(5ns * 180000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule